// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is an SPI mode-0 slave that gives serial access to a byte-wide memory array of 32K locations. A host selects the block by pulling chip select low, shifts in an 8-bit command and a 16-bit address on the serial input, and then either clocks read data out on the serial output or streams write data in. The address steps forward after every byte for as long as chip select stays low, and it wraps from the top of the 15-bit space back to zero.

The block runs on a fast system clock and samples the serial clock, chip select and data through synchronizer stages. It drives a synchronous memory port (address, write data and a write strobe, with read data returned one cycle after the address). It also takes three inputs from a neighbouring protection unit: a busy flag raised while a nonvolatile store is in progress, the current state of the write-enable latch, and a flag that says whether the address now on the memory port is write-protected. When a write sequence ends it pulses a request that clears the write-enable latch. The serial clock half-period must be at least 8 system clock cycles.

Top module: `spi_mem_slave`

## Requirements
- R1: Command byte 0x03 followed by two address bytes (most significant bit first, sampled on rising SCK) starts a read; the byte at that address then leaves on SO, bit 7 first, each bit updated after a falling SCK edge, beginning with the falling edge that ends the last address bit.
- R2: Bit 15 of the received address is ignored; only the lower 15 bits select a location.
- R3: While chip select stays low, a read continues with the byte at the next address after every 8 data bits; address 0x7FFF is followed by 0x0000.
- R4: Command byte 0x02, accepted only while the write-enable latch input is high, followed by two address bytes and data bytes, stores each data byte at successive addresses, wrapping from 0x7FFF to 0x0000; each stored byte produces exactly one single-cycle write strobe.
- R5: A 0x02 command received while the write-enable latch input is low stores nothing.
- R6: A data byte whose address is flagged as protected is not stored, but the address still advances; storing resumes at the first unprotected address, also when the burst begins inside a protected range.
- R7: A read or write command that completes while the busy input is high is ignored: no data is driven on SO and nothing is stored.
- R8: When chip select rises after an accepted write command, a single-cycle write-enable clear pulse is issued; no pulse follows a read, an ignored command or a refused write.
- R9: Chip select rising at any time aborts the transaction: a data byte with fewer than 8 bits received is discarded, and the next selection starts again at the command byte.
- R10: The SO output enable is low while chip select is high and during the command and address phases; it is high only while read data is being shifted out.
- R11: A command byte other than 0x03 or 0x02 is ignored for the rest of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the host |
| csNIn | input | 1 | Active-low chip select |
| siIn | input | 1 | Serial data from the host |
| soData | output | 1 | Serial read data |
| soOe | output | 1 | Output enable for soData (low means high-impedance) |
| memAddr | output | 15 | Memory address, also the address of the protection query |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRdata | input | 8 | Memory read data, valid one cycle after memAddr |
| storeBusy | input | 1 | High while a nonvolatile store or recall is running |
| addrProt | input | 1 | High when memAddr lies in a protected range |
| wenLatch | input | 1 | Current state of the write-enable latch |
| wenClear | output | 1 | Single-cycle request to clear the write-enable latch |

## Verification
Every serial edge passes two synchronizer stages and an edge detector, so a new SO bit is settled about four system cycles after the falling SCK edge that launches it; the bench holds each SCK level for 8 cycles and samples SO just before the following rising edge. A data byte is written to memory about three cycles after its eighth rising edge, and the clear request follows chip select release by about four cycles, so the bench compares its memory image, write-strobe count and latch state only after chip select has been high for 32 cycles. The read prefetch has two cycles of memory latency and finishes well before the falling edge that needs the next byte.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDRH,
    PH_ADDRL,
    PH_RDATA,
    PH_WDATA,
    PH_IDLE
  } phase_e;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic shiftIn;   // capture one SI bit
    logic loadHi;    // latch upper address byte
    logic loadLo;    // latch lower address byte
    logic incAddr;   // step the address
    logic fetch;     // start a memory read for the tx shifter
    logic shiftOut;  // move next bit onto SO
  } dpCtl_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic csRelease,
  output logic siS
);

  logic [STAGES-1:0] sckQ, csQ, siQ;
  logic sckPrev, csPrev;
  logic sckS, csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= '0;
      csQ     <= '1;
      siQ     <= '0;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckQ    <= {sckQ[STAGES-2:0], sckIn};
      csQ     <= {csQ[STAGES-2:0], csNIn};
      siQ     <= {siQ[STAGES-2:0], siIn};
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  assign sckS      = sckQ[STAGES-1];
  assign csS       = csQ[STAGES-1];
  assign siS       = siQ[STAGES-1];
  assign sckRise   = sckS & ~sckPrev;
  assign sckFall   = ~sckS & sckPrev;
  assign csActive  = ~csS;
  assign csRelease = csS & ~csPrev;

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPC_READ  = 8'h03,
  parameter logic [BYTE_W-1:0] OPC_WRITE = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csActive,
  input  logic              csRelease,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              storeBusy,
  input  logic              wenLatch,
  input  logic              addrProt,
  output dpCtl_t            ctl,
  output logic              memWe,
  output logic              wenClear,
  output logic              soOe
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] txCnt;
  logic             cmdRead;
  logic             writeAcc;
  logic             txStarted;
  logic             byteDone;
  logic             lastTxBit;

  always_comb begin
    byteDone     = csActive && sckRise && (bitCnt == LAST_BIT);
    ctl          = '0;
    ctl.shiftIn  = csActive && sckRise;
    ctl.loadHi   = byteDone && (phase == PH_ADDRH);
    ctl.loadLo   = byteDone && (phase == PH_ADDRL);
    ctl.shiftOut = csActive && sckFall && (phase == PH_RDATA);
    lastTxBit    = ctl.shiftOut && (txCnt == LAST_BIT);
    ctl.fetch    = (ctl.loadLo && cmdRead) || lastTxBit;
    ctl.incAddr  = lastTxBit || (byteDone && (phase == PH_WDATA));
    memWe        = byteDone && (phase == PH_WDATA) && !addrProt;
  end

  assign soOe = csActive && txStarted && (phase == PH_RDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_OPC;
      bitCnt    <= '0;
      txCnt     <= '0;
      cmdRead   <= 1'b0;
      writeAcc  <= 1'b0;
      txStarted <= 1'b0;
      wenClear  <= 1'b0;
    end else begin
      wenClear <= csRelease && writeAcc;
      if (!csActive) begin
        phase     <= PH_OPC;
        bitCnt    <= '0;
        txCnt     <= '0;
        cmdRead   <= 1'b0;
        writeAcc  <= 1'b0;
        txStarted <= 1'b0;
      end else begin
        if (sckRise) begin
          bitCnt <= bitCnt + 1'b1;
        end
        if (byteDone) begin
          unique case (phase)
            PH_OPC: begin
              if (storeBusy) begin
                phase <= PH_IDLE;
              end else if (rxByte == OPC_READ) begin
                phase   <= PH_ADDRH;
                cmdRead <= 1'b1;
              end else if (rxByte == OPC_WRITE && wenLatch) begin
                phase    <= PH_ADDRH;
                cmdRead  <= 1'b0;
                writeAcc <= 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_ADDRH: phase <= PH_ADDRL;
            PH_ADDRL: phase <= cmdRead ? PH_RDATA : PH_WDATA;
            default:  phase <= phase;
          endcase
        end
        if (ctl.shiftOut) begin
          txCnt     <= txCnt + 1'b1;
          txStarted <= 1'b1;
        end
      end
    end
  end

  // R5: a store only happens inside an accepted write command
  assert_we_needs_wen_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> writeAcc);

  // R4: one strobe per byte
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R9: deselect returns to the command phase with a cleared bit count
  assert_cs_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (phase == PH_OPC) && (bitCnt == '0));

  // R10: SO is only driven for an accepted read
  assert_oe_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> cmdRead);

  // R8: the clear request only appears once deselected
  assert_wenclr_desel_R8: assert property (@(posedge clk) disable iff (!rstN)
    wenClear |-> !csActive);

endmodule

// File: rtl/spi_mem_dp.sv
module spi_mem_dp
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              siS,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              soData
);

  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int FETCH_LAT = 2;

  logic [BYTE_W-1:0]    rxShift;
  logic [BYTE_W-1:0]    txShift;
  logic [ADDR_W-1:0]    addrReg;
  logic [FETCH_LAT-1:0] fetchPipe;

  assign rxByte   = {rxShift[BYTE_W-2:0], siS};
  assign memAddr  = addrReg;
  assign memWdata = rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      addrReg   <= '0;
      fetchPipe <= '0;
      soData    <= 1'b0;
    end else begin
      if (ctl.shiftIn) begin
        rxShift <= rxByte;
      end
      if (ctl.loadHi) begin
        addrReg[ADDR_W-1:BYTE_W] <= rxByte[HI_W-1:0];
      end else if (ctl.loadLo) begin
        addrReg[BYTE_W-1:0] <= rxByte;
      end else if (ctl.incAddr) begin
        addrReg <= addrReg + 1'b1;
      end
      fetchPipe <= {fetchPipe[FETCH_LAT-2:0], ctl.fetch};
      if (fetchPipe[FETCH_LAT-1]) begin
        txShift <= memRdata;
      end else if (ctl.shiftOut) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (ctl.shiftOut) begin
        soData <= txShift[BYTE_W-1];
      end
    end
  end

  // R3: stepping past the top address lands on zero
  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incAddr && (&addrReg) && !ctl.loadHi && !ctl.loadLo |=> addrReg == '0);

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              siIn,
  output logic              soData,
  output logic              soOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              storeBusy,
  input  logic              addrProt,
  input  logic              wenLatch,
  output logic              wenClear
);

  logic sckRise, sckFall, csActive, csRelease, siS;
  logic [BYTE_W-1:0] rxByte;
  dpCtl_t ctl;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .siIn(siIn),
    .sckRise(sckRise), .sckFall(sckFall), .csActive(csActive),
    .csRelease(csRelease), .siS(siS)
  );

  spi_mem_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csActive(csActive), .csRelease(csRelease), .rxByte(rxByte),
    .storeBusy(storeBusy), .wenLatch(wenLatch), .addrProt(addrProt),
    .ctl(ctl), .memWe(memWe), .wenClear(wenClear), .soOe(soOe)
  );

  spi_mem_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .siS(siS), .memRdata(memRdata),
    .rxByte(rxByte), .memAddr(memAddr), .memWdata(memWdata), .soData(soData)
  );

endmodule

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;

  localparam int HP    = 8;
  localparam int MDEP  = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csNIn = 1'b1, siIn = 1'b0;
  logic soData, soOe, memWe, wenClear;
  logic [14:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic storeBusy = 1'b0;
  logic addrProt;
  logic wenLatch = 1'b0;
  logic wenSetReq = 1'b0;

  logic [7:0] mem   [MDEP];
  logic [7:0] model [MDEP];
  int nChecks = 0, nErr = 0, weCount = 0, clrCount = 0;
  bit done = 0;
  logic lastOe;

  always #2 clk = ~clk;

  spi_mem_slave dut_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .siIn(siIn),
    .soData(soData), .soOe(soOe), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata), .storeBusy(storeBusy),
    .addrProt(addrProt), .wenLatch(wenLatch), .wenClear(wenClear)
  );

  function automatic bit protFn(input logic [14:0] a);
    return (a >= 15'h0200) && (a < 15'h0280);
  endfunction

  assign addrProt = protFn(memAddr);

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[9:0]] <= memWdata;
      weCount <= weCount + 1;
    end
    memRdata <= mem[memAddr[9:0]];
    if (wenClear) clrCount <= clrCount + 1;
    if (wenClear) wenLatch <= 1'b0;
    else if (wenSetReq) wenLatch <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setWen();
    @(negedge clk); wenSetReq = 1'b1;
    @(negedge clk); wenSetReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic r);
    siIn = b;
    repeat (HP) @(negedge clk);
    r = soData;
    lastOe = soOe;
    sckIn = 1'b1;
    repeat (HP) @(negedge clk);
    sckIn = 1'b0;
  endtask

  task automatic bitsX(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) bitX(tx[i], rx[i]);
  endtask

  task automatic csOn();
    @(negedge clk); csNIn = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (HP) @(negedge clk);
    csNIn = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  function automatic logic [14:0] stepA(input logic [15:0] a, input int k);
    return a[14:0] + 15'(k);
  endfunction

  task automatic memMatch(input string tag);
    int bad = -1;
    for (int i = 0; i < MDEP; i++) if (mem[i] !== model[i] && bad < 0) bad = i;
    chk(bad < 0, tag, (bad < 0) ? 0 : int'(mem[bad]), (bad < 0) ? 0 : int'(model[bad]));
  endtask

  // Read of n bytes; busy input held for the command
  task automatic doRead(input logic [15:0] a, input int n, input bit busy, input string tag);
    logic [7:0] r;
    logic [7:0] e;
    int c0 = clrCount;
    storeBusy = busy;
    csOn();
    bitsX(8'h03, 8, r);
    chk(lastOe == 1'b0, {tag, " R10 oe during command"}, lastOe, 0);
    bitsX(a[15:8], 8, r);
    bitsX(a[7:0], 8, r);
    chk(lastOe == 1'b0, {tag, " R10 oe during address"}, lastOe, 0);
    storeBusy = 1'b0;
    for (int k = 0; k < n; k++) begin
      bitsX(8'($urandom), 8, r);
      e = model[stepA(a, k) % MDEP];
      if (busy) chk(lastOe == 1'b0, {tag, " R7 busy read drives SO"}, lastOe, 0);
      else begin
        chk(r == e, {tag, " R1/R3 read data"}, r, e);
        chk(lastOe == 1'b1, {tag, " R10 oe during data"}, lastOe, 1);
      end
    end
    csOff();
    chk(soOe == 1'b0, {tag, " R10 oe after deselect"}, soOe, 0);
    chk(clrCount == c0, {tag, " R8 no clear after read"}, clrCount - c0, 0);
  endtask

  // Write of n bytes from d[], plus extra partial bits
  task automatic doWrite(input logic [15:0] a, input logic [7:0] d[8], input int n,
                         input int extraBits, input bit busy, input string tag);
    logic [7:0] r;
    logic [14:0] t;
    int w0 = weCount, c0 = clrCount, expW = 0;
    bit acc = wenLatch && !busy;
    storeBusy = busy;
    csOn();
    bitsX(8'h02, 8, r);
    storeBusy = 1'b0;
    bitsX(a[15:8], 8, r);
    bitsX(a[7:0], 8, r);
    for (int k = 0; k < n; k++) bitsX(d[k], 8, r);
    if (extraBits > 0) bitsX(8'hA5, extraBits, r);
    csOff();
    if (acc) begin
      for (int k = 0; k < n; k++) begin
        t = stepA(a, k);
        if (!protFn(t)) begin
          model[t % MDEP] = d[k];
          expW++;
        end
      end
    end
    memMatch({tag, " R4/R6 memory image"});
    chk(weCount - w0 == expW, {tag, " R4/R5/R6/R9 strobe count"}, weCount - w0, expW);
    chk(clrCount - c0 == (acc ? 1 : 0), {tag, " R8 clear pulses"}, clrCount - c0, acc ? 1 : 0);
  endtask

  task automatic doOther(input logic [7:0] op, input string tag);
    logic [7:0] r;
    int w0 = weCount, c0 = clrCount;
    bit sawOe = 0;
    csOn();
    for (int k = 0; k < 5; k++) begin
      bitsX((k == 0) ? op : 8'($urandom), 8, r);
      if (lastOe) sawOe = 1;
    end
    csOff();
    chk(!sawOe, {tag, " R11 unknown opcode drives SO"}, sawOe, 0);
    chk(weCount == w0 && clrCount == c0, {tag, " R11 unknown opcode side effect"},
        weCount - w0 + clrCount - c0, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d[8];
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < MDEP; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(soOe == 0 && memWe == 0 && wenClear == 0, "reset outputs idle R10",
        {soOe, memWe, wenClear}, 0);

    doRead(16'h0010, 1, 0, "single read R1");
    doRead(16'h8010, 2, 0, "bit15 ignored R2");
    doRead(16'h7FFE, 4, 0, "read wrap R3");

    for (int k = 0; k < 8; k++) d[k] = 8'(8'h40 + k);
    doWrite(16'h0100, d, 3, 0, 0, "write without latch R5");
    setWen();
    doWrite(16'h0100, d, 3, 0, 0, "write burst R4");
    chk(wenLatch == 0, "latch cleared after write R8", wenLatch, 0);
    doRead(16'h0100, 3, 0, "readback R4");

    setWen();
    for (int k = 0; k < 8; k++) d[k] = 8'(8'h90 + k);
    doWrite(16'h01FE, d, 4, 0, 0, "into protected R6");
    setWen();
    doWrite(16'h827E, d, 4, 0, 0, "start protected R6");
    setWen();
    doWrite(16'h7FFE, d, 4, 0, 0, "write wrap R4");

    doRead(16'h0020, 2, 1, "busy read R7");
    setWen();
    doWrite(16'h0030, d, 2, 0, 1, "busy write R7");
    chk(wenLatch == 1, "latch kept after busy write R7/R8", wenLatch, 1);
    for (int k = 0; k < 8; k++) d[k] = 8'(8'hC0 + k);
    doWrite(16'h0040, d, 1, 3, 0, "partial byte R9");
    doRead(16'h0040, 2, 0, "after abort R9");
    doOther(8'h05, "opcode 05 R11");
    doOther(8'h06, "opcode 06 R11");

    for (int it = 0; it < 25; it++) begin
      logic [15:0] a = 16'($urandom);
      int n = 1 + int'($urandom % 4);
      bit busy = ($urandom % 6) == 0;
      int kind = int'($urandom % 3);
      for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
      if (kind == 0) doRead(a, n, busy, "random read R1");
      else if (kind == 1) begin
        if ($urandom % 4 != 0) setWen();
        doWrite(a, d, n, int'($urandom % 8), busy, "random write R4");
      end else doOther(8'h80 | 8'($urandom), "random other R11");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule